// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Block Transfers

This block is a slave-only two-wire serial interface that owns a small bank of byte-wide control registers, such as per-output enable bits. The bus lines are oversampled by the system clock. Each line passes through a two-flop synchronizer and an edge detector. The block finds start and stop conditions, matches a fixed 7-bit device address, and serves block writes and block reads. The register contents are always present on a flat output bus. SDA is driven only through an open-drain pull-down enable.

No register pointer exists. In a write, the first two bytes after the address are a command byte and a byte count, and both are acknowledged and dropped. The data bytes that follow fill register 0, register 1 and so on. A read first returns the register count and then register 0 onward. The bus has no valid/ready stream at this edge: bit timing belongs to the bus master, and the slave never holds SCL low. The register outputs are plain level signals. The design target is standard-mode timing, 100 kbit/s, and the system clock must be many times faster than SCL.

Top module: `smbus_ctrl_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) puts the slave into address reception from any state, including in the middle of a transfer. A rising SDA while SCL is high (stop) returns it to idle with SDA released.
- R2: Address byte 0xD2 (device 0x69, bit 0 = 0) selects write and 0xD3 selects read, and the slave acknowledges either one by pulling SDA low during the ninth clock. Any other address byte is not acknowledged. The slave then acknowledges nothing and changes nothing until the next start.
- R3: In a write, the two bytes after the address (command and count) are acknowledged and discarded. Each later data byte, received MSB first, is acknowledged and stored in registers 0, 1, 2 and onward in arrival order.
- R4: At most NUM_REGS (10) data bytes are stored per write. A further data byte is not acknowledged, changes no register, and the slave ignores the rest of the transfer.
- R5: In a read, the first byte returned is NUM_REGS (0x0A), followed by register 0 onward, MSB first. A byte requested after the last register reads as 0xFF.
- R6: During a read, the slave releases SDA for the master's acknowledge bit. On an acknowledge (SDA low) it sends the next byte. On a not-acknowledge it keeps SDA released until the next start.
- R7: The slave changes its SDA drive only while SCL is low.
- R8: A stop or start that cuts a byte short discards the partial byte, and registers written before it keep their values.
- R9: After reset, every register reads 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| regs_o | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
On every cycle, the assertions check four things. SDA drive and register contents move only while SCL is low. The slave is pulling SDA low whenever it is in its own acknowledge slot. A stop always lands in idle, and idle or ignoring states never drive the line. The bench scenarios cover behaviour that spans whole transfers and that a per-cycle property cannot capture. This includes the address decode and the silence after a mismatch, the order in which data bytes fill registers, and the tenth-byte limit. It also includes the count-then-registers read sequence, release after a master's not-acknowledge, repeated start, and the discarding of a byte cut short by a stop.

// File: rtl/smbus_ctrl_pkg.sv
package smbus_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = q_o & ~prev;
  assign fall_o = ~q_o & prev;
endmodule

// File: rtl/smbus_cond_detect.sv
module smbus_cond_detect (
  input  logic scl_q,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  assign start_o = scl_q & sda_fall;
  assign stop_o  = scl_q & sda_rise;
endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank #(
  parameter int NUM_REGS = 10,
  parameter int IDXW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val <= 8'h00;
      else if (wr_en && wr_idx == IDXW'(i))
        val <= wr_data;
    end
    assign regs_o[i*8 +: 8] = val;
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == IDXW'(i)) rd_data = regs_o[i*8 +: 8];
  end
endmodule

// File: rtl/smbus_ctrl_slave.sv
module smbus_ctrl_slave
  import smbus_ctrl_pkg::*;
#(
  parameter int         NUM_REGS    = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int              IDXW       = $clog2(NUM_REGS + 3);
  localparam logic [IDXW-1:0] CNT_MAX    = IDXW'(NUM_REGS + 2);
  localparam logic [IDXW-1:0] HDR_BYTES  = IDXW'(2);
  localparam logic [7:0]      COUNT_BYTE = 8'(NUM_REGS);
  localparam logic [7:0]      ADDR_WR    = {DEV_ADDR, 1'b0};
  localparam logic [7:0]      ADDR_RD    = {DEV_ADDR, 1'b1};

  logic scl_q, scl_rise, scl_fall;
  logic sda_q, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i),
    .q_o(scl_q), .rise_o(scl_rise), .fall_o(scl_fall));

  smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i),
    .q_o(sda_q), .rise_o(sda_rise), .fall_o(sda_fall));

  smbus_cond_detect u_cond (
    .scl_q(scl_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_o(start_evt), .stop_o(stop_evt));

  slv_state_e      state;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic [7:0]      txsh;
  logic [IDXW-1:0] byte_cnt;
  logic            is_read;
  logic            mack_ok;

  logic            byte_done;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_data;
  logic [7:0]      tx_next;
  logic [IDXW-1:0] cnt_inc;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign wr_en     = (state == ST_RX) && byte_done &&
                     (byte_cnt >= HDR_BYTES) && (byte_cnt < CNT_MAX);
  assign wr_idx    = byte_cnt - HDR_BYTES;
  assign rd_idx    = byte_cnt - IDXW'(1);
  assign cnt_inc   = (byte_cnt == CNT_MAX) ? byte_cnt : byte_cnt + IDXW'(1);

  always_comb begin
    if (byte_cnt == '0) tx_next = COUNT_BYTE;
    else                tx_next = rd_data;
  end

  smbus_reg_bank #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(shreg),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      byte_cnt <= '0;
      is_read  <= 1'b0;
      mack_ok  <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      sda_oe   <= 1'b0;
      bitcnt   <= '0;
      byte_cnt <= '0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_oe   <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg == ADDR_WR || shreg == ADDR_RD) begin
                sda_oe  <= 1'b1;
                is_read <= shreg[0];
                state   <= ST_ACK;
              end else begin
                state   <= ST_IGNORE;
              end
            end else if (byte_cnt < CNT_MAX) begin
              sda_oe   <= 1'b1;
              byte_cnt <= cnt_inc;
              state    <= ST_ACK;
            end else begin
              state    <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              sda_oe   <= ~tx_next[7];
              txsh     <= {tx_next[6:0], 1'b0};
              byte_cnt <= cnt_inc;
              state    <= ST_TX;
            end else begin
              sda_oe   <= 1'b0;
              state    <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (byte_done) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_MACK;
          end else if (scl_fall) begin
            sda_oe <= ~txsh[7];
            txsh   <= {txsh[6:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_q;
          if (scl_fall) begin
            if (mack_ok) begin
              sda_oe   <= ~tx_next[7];
              txsh     <= {tx_next[6:0], 1'b0};
              byte_cnt <= cnt_inc;
              state    <= ST_TX;
            end else begin
              state    <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smbus_ctrl_slave_chk.sv
module smbus_ctrl_slave_chk
  import smbus_ctrl_pkg::*;
#(
  parameter int REG_W = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [REG_W-1:0] regs_o,
  input slv_state_e       state,
  input logic             stop_evt
);
  // R7: drive changes only while SCL is low
  a_r7_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R3: registers are updated only while SCL is low
  a_r3_regs_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_i);

  // R2: slave holds SDA low throughout its own acknowledge slot
  a_r2_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK) |-> sda_oe);

  // R1: a stop always lands in idle
  a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE));

  // R6: idle or ignoring states never pull the line
  a_r6_quiet_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);

  // R9: reset clears registers and releases SDA
  a_r9_reset_state: assert property (@(posedge clk)
    !rst_n |=> (regs_o == '0 && !sda_oe));
endmodule

bind smbus_ctrl_slave smbus_ctrl_slave_chk #(.REG_W(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .state(state), .stop_evt(stop_evt));

// File: tb/smbus_ctrl_slave_test.sv
`timescale 1ns/100ps
module smbus_ctrl_slave_test;
  localparam int NREG = 10;
  localparam int Q    = 20;   // quarter bit time in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_regs [NREG];

  assign sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  smbus_ctrl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic wq(input int n);
    #(n * Q * 5);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(regs_o[i*8 +: 8] == exp_regs[i], req, regs_o[i*8 +: 8], exp_regs[i]);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b0; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(1);
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    acked = !sda_line;
    wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      m_scl = 1'b1; wq(1);
      b[i] = sda_line;
      wq(1);
      m_scl = 1'b0;
    end
    wq(1);
    m_sda = give_ack ? 1'b0 : 1'b1; wq(1);
    m_scl = 1'b1; wq(2);
    m_scl = 1'b0; wq(1);
    m_sda = 1'b1;
  endtask

  task automatic t_reset;
    check(regs_o == '0, "R9 regs after reset", regs_o[31:0], 0);
    check(sda_oe == 1'b0, "R9 sda released", sda_oe, 0);
  endtask

  task automatic t_full_write;
    bit a;
    bus_start;
    send_byte(8'hD2, a); check(a, "R2 write address ack", a, 1);
    send_byte(8'h77, a); check(a, "R3 command ack", a, 1);
    send_byte(8'h0A, a); check(a, "R3 count ack", a, 1);
    for (int i = 0; i < NREG; i++) begin
      logic [7:0] v;
      v = 8'(8'h81 + i * 8'h13);
      send_byte(v, a);
      check(a, "R3 data ack", a, 1);
      exp_regs[i] = v;
    end
    bus_stop;
    check_regs("R3 registers filled in order");
  endtask

  task automatic t_read_all;
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hD3, a); check(a, "R2 read address ack", a, 1);
    read_byte(1'b1, b); check(b == 8'(NREG), "R5 count byte", b, NREG);
    for (int i = 0; i < NREG; i++) begin
      read_byte(1'b1, b);
      check(b == exp_regs[i], "R5 register readback", b, exp_regs[i]);
    end
    read_byte(1'b0, b); check(b == 8'hFF, "R5 past last register", b, 8'hFF);
    check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    bus_stop;
  endtask

  task automatic t_partial_write;
    bit a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h03, a);
    send_byte(8'h3C, a); exp_regs[0] = 8'h3C;
    send_byte(8'hC3, a); exp_regs[1] = 8'hC3;
    send_byte(8'h01, a); exp_regs[2] = 8'h01;
    bus_stop;
    check_regs("R3 partial write keeps upper registers");
  endtask

  task automatic t_overflow;
    bit a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h0C, a);
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'(i + 1), a);
      exp_regs[i] = 8'(i + 1);
    end
    send_byte(8'hEE, a); check(!a, "R4 eleventh byte not acked", a, 0);
    send_byte(8'hDD, a); check(!a, "R4 twelfth byte not acked", a, 0);
    bus_stop;
    check_regs("R4 overflow changes nothing");
  endtask

  task automatic t_bad_addr;
    bit a;
    bus_start;
    send_byte(8'hA0, a); check(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h00, a); check(!a, "R2 silent after mismatch", a, 0);
    send_byte(8'h01, a);
    send_byte(8'h55, a); check(!a, "R2 data ignored", a, 0);
    bus_stop;
    check_regs("R2 registers retained");
    bus_start;
    send_byte(8'hD0, a); check(!a, "R2 near-miss address not acked", a, 0);
    bus_stop;
  endtask

  task automatic t_restart;
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h01, a);
    send_byte(8'h5A, a); exp_regs[0] = 8'h5A;
    bus_start;   // repeated start
    send_byte(8'hD3, a); check(a, "R1 repeated start accepts address", a, 1);
    read_byte(1'b1, b); check(b == 8'(NREG), "R1 count after restart", b, NREG);
    read_byte(1'b0, b); check(b == 8'h5A, "R1 reg0 after restart", b, 8'h5A);
    bus_stop;
  endtask

  task automatic t_nack_early;
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hD3, a);
    read_byte(1'b0, b); check(b == 8'(NREG), "R6 count before nack", b, NREG);
    read_byte(1'b1, b); check(b == 8'hFF, "R6 no transmit after nack", b, 8'hFF);
    bus_stop;
  endtask

  task automatic t_cut_byte;
    bit a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop;
    check_regs("R8 stop mid-byte discards partial");
    check(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_start;
    send_byte(8'hD2, a); check(a, "R8 start mid-byte restarts address", a, 1);
    bus_stop;
    check_regs("R8 start mid-byte keeps registers");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    #20 rst_n = 1'b1;
    #50;
    t_reset;
    t_full_write;
    t_read_all;
    t_partial_write;
    t_read_all;
    t_overflow;
    t_bad_addr;
    t_restart;
    t_nack_early;
    t_cut_byte;
    t_read_all;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule